// File: doc/BRIEF.md
# Configuration Space Device Scanner

The scanner walks every location of a PCI-style configuration space: 32 buses, 32 slots per bus and 8 functions per slot. For each function it issues a read of the class/revision word over a simple request/response port. An all-ones word means the function is not populated. A word whose upper 24 bits carry the wanted class code (serial bus / IEEE 1394 / OHCI interface, 0x0C0010) marks a target controller. For each target, the scanner reads the function's first base address register and clears the low four flag bits, which gives the memory base of the controller's registers.

Each found controller is announced on a match output together with its location and base. The scanner then waits until the external initialisation logic signals that it has finished with that controller. It then resumes at function 0 of the next slot, because a device is assumed to hold at most one such controller. A global enable, sampled together with the start pulse, allows the whole walk to be skipped. A single done pulse closes every scan.

Top module: `devScan`

## Requirements
- R1: The scan visits locations in nested order (bus outer, slot middle, function innermost), starting at bus 0 / slot 0 / function 0. Each visit is one class/revision read at register offset 0x08, with the location on reqBus/reqSlot/reqFunc.
- R2: A class/revision word of 0xFFFFFFFF is taken as an absent function. It causes no further read and no match, and the scan moves on to the next function.
- R3: A function matches only when bits 31:8 of its class/revision word equal 0x0C0010. The revision byte (bits 7:0) does not affect the decision, and any other code in bits 31:8 is a non-match.
- R4: After a match has been released by ctrlDone, the remaining functions of that slot are not read. The next read is function 0 of the following slot, wrapping from slot 31 to slot 0 of the next bus.
- R5: For a matched function, the register at offset 0x10 of the same location is read. matchBase equals that word with bits 3:0 cleared.
- R6: If enable is low when start is sampled, no configuration read is issued, and scanDone pulses in the cycle after start.
- R7: At most one read is outstanding. reqValid is a one-cycle pulse and is not raised again until rspValid has returned the data for the previous request.
- R8: matchValid stays high with matchBus, matchSlot, matchFunc and matchBase unchanged until ctrlDone is sampled high. No read is issued while matchValid is high.
- R9: scanDone is a single-cycle pulse raised once per scan, after the final location (bus 31, slot 31, function 7) has been handled. The block then accepts a new start.
- R10: Out of reset, reqValid, matchValid and scanDone are low and stay low until start is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a scan when the block is idle |
| enable | input | 1 | Global enable, sampled with start |
| reqValid | output | 1 | One-cycle configuration read request |
| reqBus | output | 5 | Bus number of the request |
| reqSlot | output | 5 | Slot number of the request |
| reqFunc | output | 3 | Function number of the request |
| reqOffset | output | 8 | Register offset of the request (0x08 class, 0x10 base) |
| rspValid | input | 1 | Read data valid |
| rspData | input | 32 | Read data |
| matchValid | output | 1 | A target controller is being reported |
| matchBus | output | 5 | Bus of the reported controller |
| matchSlot | output | 5 | Slot of the reported controller |
| matchFunc | output | 3 | Function of the reported controller |
| matchBase | output | 32 | Register base of the reported controller |
| ctrlDone | input | 1 | External handling of the reported controller has finished |
| scanDone | output | 1 | One-cycle pulse at the end of a scan |

## Verification
Several properties are checked on every cycle. One read is in flight at a time. A report holds its location and base steady and issues no reads until it is released. The done pulse lasts one cycle, and a reported base has clear flag bits. Only the bench's scenarios can show which functions get read and in which order. They also show that absent and non-matching words are passed over, that a revision byte is ignored, and that the rest of a slot is skipped after a match. The enable-low path and the base value taken from the register at offset 0x10 are likewise bench-only. The bench uses a sparse memory model with response latencies of one to three cycles.

// File: rtl/devScanPkg.sv
package devScanPkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ISSUE_CLS,
    S_WAIT_CLS,
    S_ISSUE_BAR,
    S_WAIT_BAR,
    S_REPORT,
    S_FINISH
  } scanState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearLoc;
    logic stepFunc;
    logic stepSlot;
    logic loadBase;
    logic selBar;
  } pathCtl_t;

endpackage

// File: rtl/devScanPath.sv
module devScanPath
  import devScanPkg::*;
#(
  parameter int unsigned BUS_W      = 5,
  parameter int unsigned SLOT_W     = 5,
  parameter int unsigned FUNC_W     = 3,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned OFF_W      = 8,
  parameter int unsigned CLASS_CODE = 32'h000C_0010,
  parameter int unsigned CLASS_OFF  = 8'h08,
  parameter int unsigned BAR_OFF    = 8'h10,
  parameter int unsigned FLAG_BITS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathCtl_t          ctl,
  input  logic [DATA_W-1:0] rspData,
  output logic [BUS_W-1:0]  curBus,
  output logic [SLOT_W-1:0] curSlot,
  output logic [FUNC_W-1:0] curFunc,
  output logic [OFF_W-1:0]  reqOffset,
  output logic [DATA_W-1:0] baseReg,
  output logic              isTarget,
  output logic              atEnd,
  output logic              atLastSlot
);
  localparam int unsigned LOC_W  = BUS_W + SLOT_W + FUNC_W;
  localparam int unsigned SLOC_W = BUS_W + SLOT_W;
  localparam int unsigned CODE_W = DATA_W - 8;

  logic [LOC_W-1:0] loc;
  logic isAbsent;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loc <= '0;
    end else if (ctl.clearLoc) begin
      loc <= '0;
    end else if (ctl.stepFunc) begin
      loc <= loc + LOC_W'(1);
    end else if (ctl.stepSlot) begin
      loc <= {loc[LOC_W-1:FUNC_W] + SLOC_W'(1), {FUNC_W{1'b0}}};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseReg <= '0;
    end else if (ctl.loadBase) begin
      baseReg <= {rspData[DATA_W-1:FLAG_BITS], {FLAG_BITS{1'b0}}};
    end
  end

  always_comb begin
    isAbsent   = (rspData == {DATA_W{1'b1}});
    isTarget   = !isAbsent && (rspData[DATA_W-1:8] == CODE_W'(CLASS_CODE));
    atEnd      = (loc == {LOC_W{1'b1}});
    atLastSlot = (loc[LOC_W-1:FUNC_W] == {SLOC_W{1'b1}});
    reqOffset  = ctl.selBar ? OFF_W'(BAR_OFF) : OFF_W'(CLASS_OFF);
    {curBus, curSlot, curFunc} = loc;
  end

endmodule

// File: rtl/devScanCtrl.sv
module devScanCtrl
  import devScanPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     enable,
  input  logic     rspValid,
  input  logic     ctrlDone,
  input  logic     isTarget,
  input  logic     atEnd,
  input  logic     atLastSlot,
  output pathCtl_t ctl,
  output logic     reqValid,
  output logic     matchValid,
  output logic     scanDone
);
  scanState_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState  = state;
    ctl        = '0;
    reqValid   = 1'b0;
    matchValid = 1'b0;
    scanDone   = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          if (enable) begin
            ctl.clearLoc = 1'b1;
            nextState    = S_ISSUE_CLS;
          end else begin
            nextState    = S_FINISH;
          end
        end
      end
      S_ISSUE_CLS: begin
        reqValid  = 1'b1;
        nextState = S_WAIT_CLS;
      end
      S_WAIT_CLS: begin
        if (rspValid) begin
          if (isTarget) begin
            nextState = S_ISSUE_BAR;
          end else if (atEnd) begin
            nextState = S_FINISH;
          end else begin
            ctl.stepFunc = 1'b1;
            nextState    = S_ISSUE_CLS;
          end
        end
      end
      S_ISSUE_BAR: begin
        reqValid   = 1'b1;
        ctl.selBar = 1'b1;
        nextState  = S_WAIT_BAR;
      end
      S_WAIT_BAR: begin
        ctl.selBar = 1'b1;
        if (rspValid) begin
          ctl.loadBase = 1'b1;
          nextState    = S_REPORT;
        end
      end
      S_REPORT: begin
        matchValid = 1'b1;
        if (ctrlDone) begin
          if (atLastSlot) begin
            nextState = S_FINISH;
          end else begin
            ctl.stepSlot = 1'b1;
            nextState    = S_ISSUE_CLS;
          end
        end
      end
      S_FINISH: begin
        scanDone  = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/devScan.sv
module devScan
  import devScanPkg::*;
#(
  parameter int unsigned BUS_W      = 5,
  parameter int unsigned SLOT_W     = 5,
  parameter int unsigned FUNC_W     = 3,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned OFF_W      = 8,
  parameter int unsigned CLASS_CODE = 32'h000C_0010,
  parameter int unsigned CLASS_OFF  = 8'h08,
  parameter int unsigned BAR_OFF    = 8'h10,
  parameter int unsigned FLAG_BITS  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              enable,
  output logic              reqValid,
  output logic [BUS_W-1:0]  reqBus,
  output logic [SLOT_W-1:0] reqSlot,
  output logic [FUNC_W-1:0] reqFunc,
  output logic [OFF_W-1:0]  reqOffset,
  input  logic              rspValid,
  input  logic [DATA_W-1:0] rspData,
  output logic              matchValid,
  output logic [BUS_W-1:0]  matchBus,
  output logic [SLOT_W-1:0] matchSlot,
  output logic [FUNC_W-1:0] matchFunc,
  output logic [DATA_W-1:0] matchBase,
  input  logic              ctrlDone,
  output logic              scanDone
);
  pathCtl_t ctl;
  logic isTarget, atEnd, atLastSlot;
  logic [BUS_W-1:0]  curBus;
  logic [SLOT_W-1:0] curSlot;
  logic [FUNC_W-1:0] curFunc;

  devScanCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .enable(enable),
    .rspValid(rspValid), .ctrlDone(ctrlDone), .isTarget(isTarget),
    .atEnd(atEnd), .atLastSlot(atLastSlot), .ctl(ctl),
    .reqValid(reqValid), .matchValid(matchValid), .scanDone(scanDone)
  );

  devScanPath #(
    .BUS_W(BUS_W), .SLOT_W(SLOT_W), .FUNC_W(FUNC_W), .DATA_W(DATA_W),
    .OFF_W(OFF_W), .CLASS_CODE(CLASS_CODE), .CLASS_OFF(CLASS_OFF),
    .BAR_OFF(BAR_OFF), .FLAG_BITS(FLAG_BITS)
  ) i_path (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rspData(rspData),
    .curBus(curBus), .curSlot(curSlot), .curFunc(curFunc),
    .reqOffset(reqOffset), .baseReg(matchBase), .isTarget(isTarget),
    .atEnd(atEnd), .atLastSlot(atLastSlot)
  );

  // the location register serves both the request and the report
  assign reqBus    = curBus;
  assign reqSlot   = curSlot;
  assign reqFunc   = curFunc;
  assign matchBus  = curBus;
  assign matchSlot = curSlot;
  assign matchFunc = curFunc;

endmodule

// File: rtl/devScanChecker.sv
module devScanChecker #(
  parameter int unsigned BUS_W     = 5,
  parameter int unsigned SLOT_W    = 5,
  parameter int unsigned FUNC_W    = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned FLAG_BITS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              rspValid,
  input logic              matchValid,
  input logic              ctrlDone,
  input logic              scanDone,
  input logic [BUS_W-1:0]  matchBus,
  input logic [SLOT_W-1:0] matchSlot,
  input logic [FUNC_W-1:0] matchFunc,
  input logic [DATA_W-1:0] matchBase
);
  logic inFlight;

  always_ff @(posedge clk) begin
    if (!rstN)         inFlight <= 1'b0;
    else if (reqValid) inFlight <= 1'b1;
    else if (rspValid) inFlight <= 1'b0;
  end

  a_r7_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> !inFlight);

  a_r8_report_held: assert property (@(posedge clk) disable iff (!rstN)
    (matchValid && !ctrlDone) |=> (matchValid && $stable(matchBase) &&
      $stable({matchBus, matchSlot, matchFunc})));

  a_r8_no_read_in_report: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |-> !reqValid);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    scanDone |=> !scanDone);

  a_r5_base_flags_clear: assert property (@(posedge clk) disable iff (!rstN)
    matchValid |-> (matchBase[FLAG_BITS-1:0] == '0));

endmodule

bind devScan devScanChecker #(
  .BUS_W(BUS_W), .SLOT_W(SLOT_W), .FUNC_W(FUNC_W), .DATA_W(DATA_W),
  .FLAG_BITS(FLAG_BITS)
) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .rspValid(rspValid),
  .matchValid(matchValid), .ctrlDone(ctrlDone), .scanDone(scanDone),
  .matchBus(matchBus), .matchSlot(matchSlot), .matchFunc(matchFunc),
  .matchBase(matchBase)
);

// File: tb/test_devScan.sv
module test_devScan;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, enable = 1'b0;
  logic reqValid;
  logic [4:0] reqBus, reqSlot, matchBus, matchSlot;
  logic [2:0] reqFunc, matchFunc;
  logic [7:0] reqOffset;
  logic rspValid = 1'b0;
  logic [31:0] rspData = '0;
  logic matchValid, scanDone;
  logic [31:0] matchBase;
  logic ctrlDone = 1'b0;

  int checks = 0, errors = 0;
  int clsReads = 0, barReads = 0, orderErrs = 0, overlapErrs = 0, offErrs = 0;
  int doneCount = 0;

  always #4 clk = ~clk;

  devScan i_devScan (
    .clk(clk), .rstN(rstN), .start(start), .enable(enable),
    .reqValid(reqValid), .reqBus(reqBus), .reqSlot(reqSlot), .reqFunc(reqFunc),
    .reqOffset(reqOffset), .rspValid(rspValid), .rspData(rspData),
    .matchValid(matchValid), .matchBus(matchBus), .matchSlot(matchSlot),
    .matchFunc(matchFunc), .matchBase(matchBase), .ctrlDone(ctrlDone),
    .scanDone(scanDone)
  );

  // populated functions of the memory model, location = {bus,slot,func}
  function automatic logic [31:0] classWord(input logic [12:0] loc);
    case (loc)
      {5'd0, 5'd1, 3'd0}:  return 32'h0C00_1001;
      {5'd0, 5'd1, 3'd1}:  return 32'h0C00_1000;
      {5'd0, 5'd1, 3'd5}:  return 32'h0C00_1000;
      {5'd0, 5'd2, 3'd0}:  return 32'h0C00_0A00;
      {5'd0, 5'd2, 3'd3}:  return 32'h0C00_1022;
      {5'd3, 5'd7, 3'd0}:  return 32'h0C00_1100;
      {5'd3, 5'd7, 3'd1}:  return 32'h0200_0000;
      {5'd5, 5'd4, 3'd2}:  return 32'h0C00_10FF;
      {5'd31, 5'd31, 3'd7}: return 32'h0C00_1000;
      default:             return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [31:0] barWord(input logic [12:0] loc);
    return 32'hF000_00AC | (32'(loc) << 8);
  endfunction

  // expected reports, in scan order
  localparam logic [12:0] EXP_LOC [4] = '{
    {5'd0, 5'd1, 3'd0}, {5'd0, 5'd2, 3'd3}, {5'd5, 5'd4, 3'd2}, {5'd31, 5'd31, 3'd7}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // responder: latency 1..3 cycles, tracks expected scan order (R1, R4, R7)
  initial begin
    bit pend = 0;
    int cnt = 0, nreq = 0;
    logic [12:0] rloc = '0;
    logic [7:0] roff = '0;
    int expNext = 0;
    forever begin
      @(negedge clk);
      rspValid = 1'b0;
      if (pend) begin
        if (cnt == 1) begin
          rspValid = 1'b1;
          rspData  = (roff == 8'h10) ? barWord(rloc) : classWord(rloc);
          pend = 0;
        end else cnt--;
      end
      if (reqValid) begin
        if (pend) overlapErrs++;
        pend = 1;
        cnt  = 1 + (nreq % 3);
        nreq++;
        rloc = {reqBus, reqSlot, reqFunc};
        roff = reqOffset;
        if (roff == 8'h08) begin
          clsReads++;
          if (int'(rloc) != expNext) orderErrs++;
          if (classWord(rloc)[31:8] == 24'h0C0010) expNext = (int'(rloc) & ~7) + 8;
          else expNext = int'(rloc) + 1;
        end else if (roff == 8'h10) begin
          barReads++;
          if (classWord(rloc)[31:8] != 24'h0C0010) orderErrs++;
        end else offErrs++;
      end
    end
  end

  initial forever begin
    @(negedge clk);
    if (scanDone) doneCount++;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int wait_n, held, extra;
    logic [12:0] loc;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R10: quiet after reset
    check(reqValid == 1'b0, "R10 reqValid", reqValid, 0);
    check(matchValid == 1'b0, "R10 matchValid", matchValid, 0);
    check(scanDone == 1'b0, "R10 scanDone", scanDone, 0);

    // R6: enable low skips the walk
    enable = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(scanDone == 1'b1, "R6 done after start", scanDone, 1);
    repeat (3) @(negedge clk);
    check(clsReads + barReads == 0, "R6 no reads", clsReads + barReads, 0);
    check(doneCount == 1, "R9 done once (disabled)", doneCount, 1);

    // full scan
    enable = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0; enable = 1'b0;
    for (int m = 0; m < 4; m++) begin
      wait_n = 0;
      while (!matchValid && wait_n < 60000) begin @(negedge clk); wait_n++; end
      loc = {matchBus, matchSlot, matchFunc};
      check(loc == EXP_LOC[m], "R3 R4 match location", loc, EXP_LOC[m]);
      check(matchBase == (barWord(EXP_LOC[m]) & 32'hFFFF_FFF0), "R5 base",
            matchBase, barWord(EXP_LOC[m]) & 32'hFFFF_FFF0);
      held = 1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (!matchValid || reqValid || {matchBus, matchSlot, matchFunc} != EXP_LOC[m])
          held = 0;
      end
      check(held == 1, "R8 report held", held, 1);
      ctrlDone = 1'b1;
      @(negedge clk);
      ctrlDone = 1'b0;
    end
    wait_n = 0; extra = 0;
    while (doneCount < 2 && wait_n < 60000) begin
      @(negedge clk); wait_n++;
      if (matchValid) extra++;
    end
    check(extra == 0, "R2 R3 no extra match", extra, 0);
    check(doneCount == 2, "R9 done after last location", doneCount, 2);
    @(negedge clk);
    check(scanDone == 1'b0, "R9 done is a pulse", scanDone, 0);
    check(clsReads == 8176, "R2 R4 class read count", clsReads, 8176);
    check(barReads == 4, "R5 base read count", barReads, 4);
    check(orderErrs == 0, "R1 scan order", orderErrs, 0);
    check(overlapErrs == 0, "R7 single outstanding", overlapErrs, 0);
    check(offErrs == 0, "R1 offsets", offErrs, 0);
    repeat (5) @(negedge clk);
    check(doneCount == 2 && !reqValid, "R9 idle after scan", doneCount, 2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule